// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Unlock

This block is a watchdog timer. Software must keep proving that it is alive by writing a refresh key before a programmable count expires. The counter advances on one of two tick sources, which the configuration selects. A prescaler can optionally divide that tick. A window mode can also be turned on. In that mode a refresh that arrives too early, while the count is still below a programmed window value, is treated as a fault, the same as a late refresh.

The configuration is guarded. The control, timeout and window registers accept writes only while a short configuration window is open. Software opens the window by writing an unlock key to the counter register. Depending on a control bit, the key is either one 32-bit word or two 16-bit words written in a fixed order. While the window is open, each guarded register takes at most one write. Any write to the counter register that is not a recognised key counts as a protocol violation.

When the counter expires, the block raises a flag. If the interrupt is enabled, the block drives an interrupt and gives software a grace period before it requests a reset. The reset request is sticky until the block itself is reset.

Top module: `wdt_win`

## Requirements
- R1: After reset the registers read as follows. The control word at address 0 is 0x4320: 32-bit key mode bit 9, wait-run bit 8, update-allowed bit 5 and reconfiguration-complete bit 14 are set; enable bit 0 is clear. The timeout register at address 2 reads 0xFFFF, the window register at address 3 reads 0, and irq and rst_req are low.
- R2: With bit 9 set, writing 0xD928C520 to the counter register (address 1) sets the unlocked status bit 13 from the next cycle onward.
- R3: With bit 9 clear, writing 0xC520 and then 0xD928 unlocks the block. If the words come in any other order, or a non-key word is written, while enable is set, rst_req is asserted. The 16-bit refresh is 0xA602 followed by 0xB480.
- R4: The configuration window stays open for exactly CFG_WIN (128) clock cycles after the unlock write. A guarded write after the window closes has no effect.
- R5: Inside one window, a second write to the same guarded register is ignored.
- R6: Writes to the control, timeout or window registers while the block is locked are ignored.
- R7: With enable set, the counter increments on each tick of the source chosen by bit 1 (bit 2 selects the ÷PRE_DIV prescaler) and stops at the timeout value. In the cycle after the count reaches the timeout, flag bit 12 sets. If interrupt enable (bit 3) is clear, rst_req asserts in that same cycle. rst_req then stays high.
- R8: If interrupt enable is set, irq is high while the flag is set, and rst_req rises exactly GRACE (128) cycles after the flag.
- R9: Writing 1 to bit 12 of the control register clears the flag, and irq drops with it. This works whether or not the block is unlocked.
- R10: With window mode (bit 4) set, a refresh while the count is below the window value asserts rst_req. A refresh at or above the window value clears the count to 0 with no reset.
- R11: A wrong key while enable is set asserts rst_req. The same key while enable is clear has no effect.
- R12: If the configuration window closes with the clock-source bit changed, the counter is held at 0 and bit 14 stays 0. This lasts until three ticks of the old source and three ticks of the new source have arrived. Bit 14 reads 1 one cycle later, and counting resumes.
- R13: While update-allowed (bit 5) is clear, the unlock key does not open a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 counter/key, 2 timeout, 3 window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as write |
| rd_data | output | 32 | Combinational read data |
| src_tick | input | 2 | Tick enables of the two selectable counting sources |
| irq | output | 1 | Timeout interrupt |
| rst_req | output | 1 | Sticky reset request |

## Verification
Most internal faults in this block show up on the read port within one cycle. A key decoder left in the wrong state shows up as a missing unlocked bit, or as a rst_req after a legal word pair. A wrong window-length counter flips the unlocked bit one cycle early or late at the 128-cycle boundary. Faults in the write-once locks or the window gating leave a stale or overwritten timeout or window value on the very next read. Errors in the expiry path and the clock-switch hold only become visible later: as a rst_req that rises off the exact grace cycle, or as a count that is non-zero, or a completion bit that is set, before the sixth counted tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_CNT   = 2'd1,
    A_TOVAL = 2'd2,
    A_WIN   = 2'd3
  } wdt_addr_e;

  // Control field layout, bit 0 first from the bottom.
  typedef struct packed {
    logic [1:0] test;
    logic       cmd32;
    logic       run_wait;
    logic       run_stop;
    logic       run_dbg;
    logic       upd_ok;
    logic       win_en;
    logic       int_en;
    logic       pres;
    logic       clk_sel;
    logic       en;
  } wdt_ctrl_t;

  localparam int CTRL_W   = $bits(wdt_ctrl_t);
  localparam int FLAG_BIT = CTRL_W;

  localparam wdt_ctrl_t CTRL_RST = '{
    test: 2'b00, cmd32: 1'b1, run_wait: 1'b1, run_stop: 1'b0, run_dbg: 1'b0,
    upd_ok: 1'b1, win_en: 1'b0, int_en: 1'b0, pres: 1'b0, clk_sel: 1'b0, en: 1'b0
  };

  // Assemble the readable control word: fields, then flag, unlocked, complete.
  function automatic logic [31:0] ctrl_word(wdt_ctrl_t c, logic flag, logic ulk,
                                            logic rcs);
    return {{(32 - CTRL_W - 3){1'b0}}, rcs, ulk, flag, c};
  endfunction

  // A refresh is early only in window mode and below the window value.
  function automatic logic refresh_early(logic win_mode, logic [31:0] cnt,
                                         logic [31:0] win);
    return win_mode && (cnt < win);
  endfunction

endpackage

// File: rtl/wdt_keydec.sv
module wdt_keydec #(
  parameter logic [31:0] UNLOCK32  = 32'hD928_C520,
  parameter logic [31:0] REFRESH32 = 32'hB480_A602,
  parameter logic [15:0] UNLOCK_LO = 16'hC520,
  parameter logic [15:0] UNLOCK_HI = 16'hD928,
  parameter logic [15:0] REFR_LO   = 16'hA602,
  parameter logic [15:0] REFR_HI   = 16'hB480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key,
  input  logic        mode32,
  output logic        unlock_ev,
  output logic        refresh_ev,
  output logic        viol_ev
);

  typedef enum logic [1:0] {K_IDLE, K_UNL, K_REF} kst_e;
  kst_e st, st_nxt;

  always_comb begin
    unlock_ev  = 1'b0;
    refresh_ev = 1'b0;
    viol_ev    = 1'b0;
    st_nxt     = st;
    if (key_wr) begin
      if (mode32) begin
        st_nxt = K_IDLE;
        if (key == UNLOCK32)       unlock_ev  = 1'b1;
        else if (key == REFRESH32) refresh_ev = 1'b1;
        else                       viol_ev    = 1'b1;
      end else begin
        unique case (st)
          K_IDLE: begin
            if (key == {16'h0, UNLOCK_LO})    st_nxt = K_UNL;
            else if (key == {16'h0, REFR_LO}) st_nxt = K_REF;
            else                              viol_ev = 1'b1;
          end
          K_UNL: begin
            st_nxt = K_IDLE;
            if (key == {16'h0, UNLOCK_HI}) unlock_ev = 1'b1;
            else                           viol_ev   = 1'b1;
          end
          default: begin
            st_nxt = K_IDLE;
            if (key == {16'h0, REFR_HI}) refresh_ev = 1'b1;
            else                         viol_ev    = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= K_IDLE;
    else        st <= st_nxt;
  end

endmodule

// File: rtl/wdt_oneshot.sv
module wdt_oneshot #(
  parameter int LEN = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic done
);

  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  logic [W-1:0] left;

  assign done = active && (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      left   <= '0;
    end else if (active) begin
      if (left == '0) active <= 1'b0;
      else            left   <= left - 1'b1;
    end else if (start) begin
      active <= 1'b1;
      left   <= W'(LEN - 1);
    end
  end

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CW         = 16,
  parameter int PRE_DIV    = 256,
  parameter int HOLD_TICKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    src_tick,
  input  logic          sel,
  input  logic          pres,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  input  logic          hold_go,
  input  logic          old_sel,
  output logic [CW-1:0] cnt,
  output logic          hold,
  output logic          hold_done
);

  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(PRE_DIV - 1);
  localparam logic [HW-1:0] H_FULL = HW'(HOLD_TICKS);

  logic [PW-1:0] pcnt;
  logic [HW-1:0] n_old, n_new;
  logic          old_q, src_new, src_old, step;

  assign src_new   = src_tick[sel];
  assign src_old   = src_tick[old_q];
  assign step      = src_new && (!pres || pcnt == P_LAST);
  assign hold_done = hold && (n_old == H_FULL) && (n_new == H_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pcnt <= '0;
    else if (src_new && pres) pcnt <= (pcnt == P_LAST) ? '0 : pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= 1'b0;
      old_q <= 1'b0;
      n_old <= '0;
      n_new <= '0;
    end else if (hold_go) begin
      hold  <= 1'b1;
      old_q <= old_sel;
      n_old <= '0;
      n_new <= '0;
    end else if (hold) begin
      if (hold_done) hold <= 1'b0;
      else begin
        if (src_old && n_old != H_FULL) n_old <= n_old + 1'b1;
        if (src_new && n_new != H_FULL) n_new <= n_new + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr || hold || hold_go)   cnt <= '0;
    else if (run && step && cnt != limit) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdt_win.sv
module wdt_win
  import wdt_pkg::*;
#(
  parameter int          CW         = 16,
  parameter int          CFG_WIN    = 128,
  parameter int          GRACE      = 128,
  parameter int          PRE_DIV    = 256,
  parameter int          HOLD_TICKS = 3,
  parameter logic [31:0] UNLOCK32   = 32'hD928_C520,
  parameter logic [31:0] REFRESH32  = 32'hB480_A602,
  parameter logic [15:0] UNLOCK_LO  = 16'hC520,
  parameter logic [15:0] UNLOCK_HI  = 16'hD928,
  parameter logic [15:0] REFR_LO    = 16'hA602,
  parameter logic [15:0] REFR_HI    = 16'hB480
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [1:0]  src_tick,
  output logic        irq,
  output logic        rst_req
);

  localparam logic [CW-1:0] TOVAL_RST = '1;

  wdt_ctrl_t     ctrl;
  logic [CW-1:0] toval, winv, cnt;
  logic          flag, rcs, expired, sel_at_unlock;
  logic [2:0]    wr_done;

  // Named internal events.
  logic key_wr, unlock_ev, refresh_ev, viol_ev;
  logic unlock_ok, cfg_open, close_ev;
  logic acc_ctrl, acc_toval, acc_win;
  logic ref_ok, win_bad, ref_clr, viol_hit;
  logic hold_go, hold, hold_done;
  logic tmo_now, grace_go, grace_on, grace_done;
  logic int_en;

  assign key_wr = wr_en && (wr_addr == A_CNT);
  assign int_en = ctrl.int_en;

  wdt_keydec #(
    .UNLOCK32(UNLOCK32), .REFRESH32(REFRESH32), .UNLOCK_LO(UNLOCK_LO),
    .UNLOCK_HI(UNLOCK_HI), .REFR_LO(REFR_LO), .REFR_HI(REFR_HI)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key(wr_data), .mode32(ctrl.cmd32),
    .unlock_ev(unlock_ev), .refresh_ev(refresh_ev), .viol_ev(viol_ev)
  );

  assign unlock_ok = unlock_ev && ctrl.upd_ok && !cfg_open;

  wdt_oneshot #(.LEN(CFG_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .start(unlock_ok), .active(cfg_open), .done(close_ev)
  );

  assign acc_ctrl  = wr_en && wr_addr == A_CTRL  && cfg_open && !wr_done[0];
  assign acc_toval = wr_en && wr_addr == A_TOVAL && cfg_open && !wr_done[1];
  assign acc_win   = wr_en && wr_addr == A_WIN   && cfg_open && !wr_done[2];

  assign ref_ok   = refresh_ev && ctrl.en;
  assign win_bad  = ref_ok && refresh_early(ctrl.win_en, 32'(cnt), 32'(winv));
  assign ref_clr  = ref_ok && !win_bad;
  assign viol_hit = viol_ev && ctrl.en;
  assign hold_go  = close_ev && (ctrl.clk_sel != sel_at_unlock);

  wdt_count #(.CW(CW), .PRE_DIV(PRE_DIV), .HOLD_TICKS(HOLD_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(ctrl.clk_sel),
    .pres(ctrl.pres), .run(ctrl.en), .clr(ref_clr), .limit(toval),
    .hold_go(hold_go), .old_sel(sel_at_unlock), .cnt(cnt), .hold(hold),
    .hold_done(hold_done)
  );

  assign tmo_now  = ctrl.en && !hold && (cnt == toval) && !expired;
  assign grace_go = tmo_now && ctrl.int_en;

  wdt_oneshot #(.LEN(GRACE)) u_grace (
    .clk(clk), .rst_n(rst_n), .start(grace_go), .active(grace_on), .done(grace_done)
  );

  // Guarded registers and write-once bookkeeping.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl          <= CTRL_RST;
      toval         <= TOVAL_RST;
      winv          <= '0;
      wr_done       <= '0;
      sel_at_unlock <= 1'b0;
    end else begin
      if (unlock_ok) begin
        wr_done       <= '0;
        sel_at_unlock <= ctrl.clk_sel;
      end else begin
        if (acc_ctrl)  begin ctrl  <= wdt_ctrl_t'(wr_data[CTRL_W-1:0]); wr_done[0] <= 1'b1; end
        if (acc_toval) begin toval <= wr_data[CW-1:0];                  wr_done[1] <= 1'b1; end
        if (acc_win)   begin winv  <= wr_data[CW-1:0];                  wr_done[2] <= 1'b1; end
      end
    end
  end

  // Status: flag, completion, expiry and the sticky reset request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      rcs     <= 1'b1;
      expired <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL && wr_data[FLAG_BIT]) flag <= 1'b0;
      if (tmo_now) flag <= 1'b1;

      if (acc_ctrl && !unlock_ok) rcs <= 1'b0;
      else if ((close_ev && !hold_go) || hold_done) rcs <= 1'b1;

      if (tmo_now)      expired <= 1'b1;
      else if (ref_clr) expired <= 1'b0;

      if (viol_hit || win_bad || (tmo_now && !ctrl.int_en) || grace_done)
        rst_req <= 1'b1;
    end
  end

  assign irq = flag && ctrl.int_en;

  always_comb begin
    unique case (wdt_addr_e'(rd_addr))
      A_CTRL:  rd_data = ctrl_word(ctrl, flag, cfg_open, rcs);
      A_CNT:   rd_data = 32'(cnt);
      A_TOVAL: rd_data = 32'(toval);
      default: rd_data = 32'(winv);
    endcase
  end

endmodule

// File: rtl/wdt_win_chk.sv
module wdt_win_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_open,
  input logic          unlock_ok,
  input logic          hold,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] toval,
  input logic          flag,
  input logic          irq,
  input logic          rst_req,
  input logic          ref_clr
);

  p_rst_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  p_open_from_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(unlock_ok));

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_hold_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (cnt == '0));

  p_toval_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(toval) |-> $past(cfg_open));

  p_refresh_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clr |=> (cnt == '0));

endmodule

bind wdt_win wdt_win_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .unlock_ok(unlock_ok),
  .hold(hold), .cnt(cnt), .toval(toval), .flag(flag), .irq(irq),
  .rst_req(rst_req), .ref_clr(ref_clr)
);

// File: tb/wdt_win_tb.sv
module wdt_win_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CFG_WIN    = 128;
  localparam int GRACE      = 128;

  logic        clk, rst_n, wr_en, irq, rst_req;
  logic [1:0]  wr_addr, rd_addr, src_tick;
  logic [31:0] wr_data, rd_data;
  int          errs, checks;
  bit          done;

  wdt_win u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_tick(src_tick), .irq(irq),
    .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct packed {
    logic        m32;
    logic [1:0]  n;
    logic [31:0] w0;
    logic [31:0] w1;
    logic        e_ulk;
    logic        e_rst;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{1'b1, 2'd1, 32'hD928C520, 32'h0,      1'b1, 1'b0},
    '{1'b1, 2'd1, 32'h12345678, 32'h0,      1'b0, 1'b1},
    '{1'b0, 2'd2, 32'h0000C520, 32'h0000D928, 1'b1, 1'b0},
    '{1'b0, 2'd2, 32'h0000D928, 32'h0000C520, 1'b0, 1'b1},
    '{1'b1, 2'd1, 32'hB480A602, 32'h0,      1'b0, 1'b0},
    '{1'b0, 2'd2, 32'h0000A602, 32'h0000B480, 1'b0, 1'b0},
    '{1'b0, 2'd2, 32'h0000C520, 32'h0000B480, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; src_tick = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(2'd1, 32'hD928C520);
  endtask

  task automatic wait_flag(output bit seen);
    logic [31:0] d;
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      rd(2'd0, d);
      if (d[12]) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit seen;
    errs = 0; checks = 0; done = 1'b0;

    // R1: reset values
    do_reset();
    rd(2'd0, d); chk("R1 ctrl", d, 32'h4320);
    rd(2'd2, d); chk("R1 toval", d, 32'hFFFF);
    rd(2'd3, d); chk("R1 win", d, 32'h0);
    chk("R1 irq/rst", {30'b0, irq, rst_req}, 32'h0);

    // R6: locked writes ignored; R11: bad key ignored while disabled
    wr(2'd2, 32'h7);
    rd(2'd2, d); chk("R6 toval locked", d, 32'hFFFF);
    wr(2'd1, 32'h1234);
    chk("R11 bad key disabled", {31'b0, rst_req}, 32'h0);

    // Table: key sequences with enable set (R2, R3, R11)
    for (int i = 0; i < 7; i++) begin
      do_reset();
      unlock();
      wr(2'd0, 32'h21 | (32'(VEC[i].m32) << 9));
      repeat (CFG_WIN) @(negedge clk);
      if (VEC[i].n >= 2'd1) wr(2'd1, VEC[i].w0);
      if (VEC[i].n == 2'd2) wr(2'd1, VEC[i].w1);
      rd(2'd0, d);
      chk($sformatf("R2/R3 vec%0d unlocked", i), {31'b0, d[13]}, {31'b0, VEC[i].e_ulk});
      chk($sformatf("R3/R11 vec%0d rst_req", i), {31'b0, rst_req}, {31'b0, VEC[i].e_rst});
    end

    // R4, R5: window length and write-once
    do_reset();
    unlock();
    rd(2'd0, d); chk("R2 unlocked bit", {31'b0, d[13]}, 32'h1);
    repeat (CFG_WIN - 1) @(negedge clk);
    rd(2'd0, d); chk("R4 last open cycle", {31'b0, d[13]}, 32'h1);
    @(negedge clk);
    rd(2'd0, d); chk("R4 closed", {31'b0, d[13]}, 32'h0);
    wr(2'd3, 32'h9);
    rd(2'd3, d); chk("R4 write after close", d, 32'h0);
    unlock();
    wr(2'd2, 32'd10);
    wr(2'd2, 32'd20);
    rd(2'd2, d); chk("R5 write once", d, 32'd10);

    // R7: timeout, interrupt disabled
    do_reset();
    unlock();
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h221);
    src_tick = 2'b01;
    wait_flag(seen);
    chk("R7 flag seen", {31'b0, seen}, 32'h1);
    chk("R7 rst with flag", {30'b0, rst_req, irq}, 32'h2);
    rd(2'd1, d); chk("R7 count at limit", d, 32'd5);
    src_tick = 2'b00;

    // R8, R9: interrupt then grace
    do_reset();
    unlock();
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h229);
    src_tick = 2'b01;
    wait_flag(seen);
    src_tick = 2'b00;
    chk("R8 irq", {30'b0, irq, rst_req}, 32'h2);
    repeat (GRACE - 1) @(negedge clk);
    chk("R8 before grace end", {31'b0, rst_req}, 32'h0);
    @(negedge clk);
    chk("R8 grace end", {31'b0, rst_req}, 32'h1);
    wr(2'd0, 32'h1000);
    rd(2'd0, d); chk("R9 flag cleared", {30'b0, d[12], irq}, 32'h0);

    // R10: window mode, early then boundary refresh
    do_reset();
    unlock();
    wr(2'd2, 32'd100);
    wr(2'd3, 32'd20);
    wr(2'd0, 32'h231);
    src_tick = 2'b01; repeat (10) @(negedge clk); src_tick = 2'b00;
    wr(2'd1, 32'hB480A602);
    chk("R10 early refresh", {31'b0, rst_req}, 32'h1);
    do_reset();
    unlock();
    wr(2'd2, 32'd100);
    wr(2'd3, 32'd20);
    wr(2'd0, 32'h231);
    src_tick = 2'b01; repeat (20) @(negedge clk); src_tick = 2'b00;
    rd(2'd1, d); chk("R10 count at window", d, 32'd20);
    wr(2'd1, 32'hB480A602);
    rd(2'd1, d); chk("R10 refresh clears", d, 32'd0);
    chk("R10 no reset", {31'b0, rst_req}, 32'h0);

    // R12: clock-source switch hold
    do_reset();
    unlock();
    wr(2'd0, 32'h223);
    repeat (CFG_WIN - 1) @(negedge clk);
    rd(2'd0, d); chk("R12 closed, not complete", {30'b0, d[13], d[14]}, 32'h0);
    src_tick = 2'b10; repeat (5) @(negedge clk); src_tick = 2'b00;
    rd(2'd1, d); chk("R12 held at zero", d, 32'd0);
    src_tick = 2'b01; repeat (3) @(negedge clk); src_tick = 2'b00;
    rd(2'd0, d); chk("R12 still holding", {31'b0, d[14]}, 32'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R12 complete", {31'b0, d[14]}, 32'h1);
    src_tick = 2'b10; repeat (4) @(negedge clk); src_tick = 2'b00;
    rd(2'd1, d); chk("R12 counts new source", d, 32'd4);

    // R13: unlock refused without update-allowed
    do_reset();
    unlock();
    wr(2'd0, 32'h200);
    repeat (CFG_WIN) @(negedge clk);
    unlock();
    rd(2'd0, d); chk("R13 no unlock", {31'b0, d[13]}, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule